// File: doc/BRIEF.md
# Command-Driven LIFO Stack

This block is a clocked last-in-first-out store for small data words. On every rising clock edge it carries out one operation, chosen by a 2-bit command: stay idle, push the data input, pop the newest entry onto the output, or peek at an entry some distance below the newest one. A peek does not change the stored entries or the occupancy.

The cells form a ring of DEPTH slots. A write position marks where the next push lands, and the newest entry sits one slot behind it. A push onto a full stack overwrites the oldest entry and the stack stays full. A pop from an empty stack moves the write position one slot back and returns whatever that slot holds, and the stack stays empty. No error is reported in either case.

An occupancy state machine tracks the fill level and drives the full and empty outputs. It has three states: OCC_EMPTY, OCC_PART and OCC_FULL. These are its transitions:

- OCC_EMPTY goes to OCC_PART on a push.
- OCC_PART goes to OCC_FULL on a push that fills the last free slot.
- OCC_PART goes to OCC_EMPTY on a pop that removes the last entry.
- OCC_FULL goes to OCC_PART on a pop.
- OCC_EMPTY stays where it is on a pop (underflow wrap).
- OCC_FULL stays where it is on a push (overflow wrap).
- Every other command leaves the state unchanged.

Top module: `stk_cmd_stack`

## Requirements
- R1: While rst is high at a clock edge, the block goes to a defined state. After that edge dout is 0, empty is 1, full is 0, the write position is slot 0, and every cell holds 0. A peek at any index after reset returns 0.
- R2: Command 0 (idle) leaves dout, full, empty and all stored cells unchanged.
- R3: Command 1 (push) writes din into the slot at the write position, and the write position advances by one, modulo DEPTH. A following peek at index 0 returns that value.
- R4: Command 2 (pop) loads dout with the newest entry and removes it, so pops return entries in reverse order of their pushes.
- R5: Command 3 (peek) loads dout with the entry idx places below the newest, with index 0 being the newest. It leaves the cells, the write position, full and empty unchanged.
- R6: The peek index is reduced modulo DEPTH. With DEPTH 5, index values 5, 6 and 7 select the same entries as 0, 1 and 2.
- R7: A push while full overwrites the oldest slot, and full stays 1.
- R8: A pop while empty moves the write position one slot back (from slot 0 to slot DEPTH-1) and returns that slot's content, and empty stays 1.
- R9: full is 1 exactly when DEPTH entries are held, and empty is 1 exactly when none are held. The two are never 1 together.
- R10: dout is registered. It changes only on pop or peek and holds its value through idle and push cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | Operation: 0 idle, 1 push, 2 pop, 3 peek |
| din | input | DATA_W (4) | Value written by a push |
| idx | input | IDX_W (3) | Peek offset below the newest entry |
| dout | output | DATA_W (4) | Registered result of the last pop or peek |
| full | output | 1 | DEPTH entries are held |
| empty | output | 1 | No entries are held |

## Verification
The hardest situation to reach is a peek or pop after the ring has wrapped, where the write position is no longer aligned with slot 0. There, the modulo index and the backward pointer step both cross the slot DEPTH-1 to slot 0 boundary. The stimulus gets there by overfilling the stack with more pushes than DEPTH and then sweeping every index value at each fill level. It then pops past empty so the pointer runs backward through the wrap. Finally, a long pseudo-random command stream mixes all four commands so that overflow and underflow happen from many different write positions. A reference ring model in the bench tracks the expected contents throughout.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_PUSH = 2'd1,
        CMD_POP  = 2'd2,
        CMD_PEEK = 2'd3
    } stk_cmd_e;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } stk_occ_e;

endpackage

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_cmd_e         cmd,
    output logic [PTR_W-1:0] wr_slot,
    output logic [PTR_W-1:0] top_slot,
    output logic             push_en,
    output logic             full,
    output logic             empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] SLOT_MAX = PTR_W'(DEPTH - 1);

    stk_occ_e         occ_q, occ_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] wp_q, wp_d;
    logic [PTR_W-1:0] wp_inc, wp_dec;

    // ring neighbours of the write position
    always_comb begin
        wp_inc = (wp_q == SLOT_MAX) ? '0 : wp_q + PTR_W'(1);
        wp_dec = (wp_q == '0) ? SLOT_MAX : wp_q - PTR_W'(1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= OCC_EMPTY;
            cnt_q <= '0;
            wp_q  <= '0;
        end else begin
            occ_q <= occ_d;
            cnt_q <= cnt_d;
            wp_q  <= wp_d;
        end
    end

    // next state, fill count and write position
    always_comb begin
        occ_d = occ_q;
        cnt_d = cnt_q;
        wp_d  = wp_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (cmd == CMD_PUSH) begin
                    occ_d = (DEPTH == 1) ? OCC_FULL : OCC_PART;
                    cnt_d = cnt_q + CNT_W'(1);
                    wp_d  = wp_inc;
                end else if (cmd == CMD_POP) begin
                    wp_d  = wp_dec;
                end
            end
            OCC_PART: begin
                if (cmd == CMD_PUSH) begin
                    if (cnt_q == CNT_LAST) occ_d = OCC_FULL;
                    cnt_d = cnt_q + CNT_W'(1);
                    wp_d  = wp_inc;
                end else if (cmd == CMD_POP) begin
                    if (cnt_q == CNT_W'(1)) occ_d = OCC_EMPTY;
                    cnt_d = cnt_q - CNT_W'(1);
                    wp_d  = wp_dec;
                end
            end
            OCC_FULL: begin
                if (cmd == CMD_PUSH) begin
                    cnt_d = CNT_MAX;
                    wp_d  = wp_inc;
                end else if (cmd == CMD_POP) begin
                    occ_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PART;
                    cnt_d = cnt_q - CNT_W'(1);
                    wp_d  = wp_dec;
                end
            end
            default: begin
                occ_d = OCC_EMPTY;
                cnt_d = '0;
                wp_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        wr_slot  = wp_q;
        top_slot = wp_dec;
        push_en  = (cmd == CMD_PUSH);
        full     = (occ_q == OCC_FULL);
        empty    = (occ_q == OCC_EMPTY);
    end

endmodule

// File: rtl/stk_slot_sel.sv
module stk_slot_sel #(
    parameter int DEPTH = 5,
    parameter int PTR_W = 3,
    parameter int IDX_W = 3
) (
    input  logic [PTR_W-1:0] top_slot,
    input  logic             use_idx,
    input  logic [IDX_W-1:0] idx,
    output logic [PTR_W-1:0] rd_slot
);

    localparam int CW   = ((IDX_W > PTR_W) ? IDX_W : PTR_W) + 1;
    localparam int NSUB = (2 ** IDX_W) / DEPTH + 1;
    localparam logic [CW-1:0] DEP_C = CW'(DEPTH);

    logic [CW-1:0] off;
    logic [CW-1:0] sum;

    always_comb begin
        off = use_idx ? CW'(idx) : '0;
        for (int k = 0; k < NSUB; k++) begin
            if (off >= DEP_C) off = off - DEP_C;
        end
        sum = CW'(top_slot) + DEP_C - off;
        if (sum >= DEP_C) sum = sum - DEP_C;
        rd_slot = sum[PTR_W-1:0];
    end

endmodule

// File: rtl/stk_cell_ring.sv
module stk_cell_ring #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 5,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= '0;
            end else if (we && (waddr == PTR_W'(i))) begin
                cells[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == PTR_W'(i)) rdata = cells[i];
        end
    end

endmodule

// File: rtl/stk_cmd_stack.sv
module stk_cmd_stack
    import stk_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stk_cmd_e          op;
    logic [PTR_W-1:0]  wr_slot, top_slot, rd_slot;
    logic              push_en;
    logic [DATA_W-1:0] rdata;

    assign op = stk_cmd_e'(cmd);

    stk_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) ctrl_i (
        .clk(clk), .rst(rst), .cmd(op),
        .wr_slot(wr_slot), .top_slot(top_slot), .push_en(push_en),
        .full(full), .empty(empty)
    );

    stk_slot_sel #(.DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W)) sel_i (
        .top_slot(top_slot), .use_idx(op == CMD_PEEK), .idx(idx),
        .rd_slot(rd_slot)
    );

    stk_cell_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) ring_i (
        .clk(clk), .rst(rst), .we(push_en), .waddr(wr_slot), .wdata(din),
        .raddr(rd_slot), .rdata(rdata)
    );

    // registered result of pop or peek
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (op == CMD_POP || op == CMD_PEEK) begin
            dout <= rdata;
        end
    end

endmodule

// File: rtl/stk_cmd_stack_chk.sv
module stk_cmd_stack_chk #(
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd,
    input logic [DATA_W-1:0] dout,
    input logic              full,
    input logic              empty
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dout == '0 && empty && !full));

    a_r2_idle_flags: assert property (@(posedge clk) disable iff (rst)
        cmd == 2'd0 |=> ($stable(full) && $stable(empty)));

    a_r3_push_not_empty: assert property (@(posedge clk) disable iff (rst)
        cmd == 2'd1 |=> !empty);

    a_r4_pop_not_full: assert property (@(posedge clk) disable iff (rst)
        cmd == 2'd2 |=> !full);

    a_r5_peek_flags: assert property (@(posedge clk) disable iff (rst)
        cmd == 2'd3 |=> ($stable(full) && $stable(empty)));

    a_r7_full_push: assert property (@(posedge clk) disable iff (rst)
        (full && cmd == 2'd1) |=> full);

    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && cmd == 2'd2) |=> empty);

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    a_r10_dout_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'd0 || cmd == 2'd1) |=> $stable(dout));

endmodule

bind stk_cmd_stack stk_cmd_stack_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .cmd(cmd), .dout(dout), .full(full), .empty(empty)
);

// File: tb/stk_cmd_stack_tb.sv
`timescale 1ns/1ps
module stk_cmd_stack_tb_top;

    localparam int D = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmd = 2'd0;
    logic [3:0] din = '0;
    logic [2:0] idx = '0;
    logic [3:0] dout;
    logic       full, empty;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    int m_mem [D];
    int m_wp;
    int m_cnt;
    int m_dout;
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    stk_cmd_stack dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .din(din), .idx(idx),
        .dout(dout), .full(full), .empty(empty)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < D; i++) m_mem[i] = 0;
        m_wp = 0; m_cnt = 0; m_dout = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; cmd = 2'd0;
        @(posedge clk); #1;
        model_clear();
        chk("R1 dout", 32'(dout), 0);
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] c, input logic [3:0] d, input logic [2:0] ix);
        string tag;
        int s;
        bit was_full;
        bit was_empty;
        was_full  = (m_cnt == D);
        was_empty = (m_cnt == 0);
        @(negedge clk); cmd = c; din = d; idx = ix;
        @(posedge clk); #1;
        case (c)
            2'd0: tag = "R2 idle";
            2'd1: begin
                m_mem[m_wp] = int'(d);
                m_wp = (m_wp + 1) % D;
                if (m_cnt < D) m_cnt++;
                tag = was_full ? "R7 push-full" : "R10 push-hold";
            end
            2'd2: begin
                m_wp = (m_wp + D - 1) % D;
                m_dout = m_mem[m_wp];
                if (m_cnt > 0) m_cnt--;
                tag = was_empty ? "R8 pop-empty" : "R4 pop";
            end
            default: begin
                s = (m_wp + D - 1 + D - (int'(ix) % D)) % D;
                m_dout = m_mem[s];
                tag = (ix >= D) ? "R6 peek-wrap" : "R5 peek";
            end
        endcase
        chk({tag, " dout"}, 32'(dout), 32'(m_dout));
        chk("R9 full", 32'(full), 32'(m_cnt == D));
        chk("R9 empty", 32'(empty), 32'(m_cnt == 0));
    endtask

    task automatic peek_all();
        for (int i = 0; i < 8; i++) do_op(2'd3, 4'h0, 3'(i));
    endtask

    initial begin
        model_clear();
        do_reset();
        // R1: every cell reads zero after reset
        peek_all();
        // R8: underflow from reset wraps to the last slot
        do_op(2'd2, 4'h0, 3'd0);
        do_op(2'd2, 4'h0, 3'd0);
        do_reset();
        // R3, R5, R6, R7: fill past capacity, sweeping indices each level
        for (int n = 0; n < 8; n++) begin
            do_op(2'd1, 4'(n * 3 + 1), 3'd0);
            do_op(2'd0, 4'hF, 3'd7);
            peek_all();
        end
        // R4, R8: drain past empty
        for (int n = 0; n < 8; n++) begin
            do_op(2'd2, 4'h0, 3'd0);
            do_op(2'd0, 4'h0, 3'd0);
        end
        peek_all();
        // mixed pseudo-random stream over all commands
        for (int n = 0; n < 1500; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            do_op(seed[17:16], seed[23:20], seed[27:25]);
        end
        // R1: reset in the middle of traffic
        do_reset();
        peek_all();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule